// File: doc/BRIEF.md
# Cartridge ROM/RAM window mapper

This block decodes the address bus of an 8-bit, 6502-style processor for a game cartridge that carries 128 KiB of program ROM and 8 KiB of work RAM. Given the CPU address, it produces a 17-bit ROM address, a 13-bit RAM address, a chip select for each memory and a RAM write enable. The decode is purely combinational. The memory arrays sit outside the block.

Two switchable 4 KiB ROM pages and the work RAM are cut into pieces of 1, 2 and 3 KiB. These pieces are spread over the 0x6000–0x7FFF region and over part of the upper map. Every other upper address reads a fixed 32 KiB ROM region. The page numbers are not taken from the data bus. They are taken from the low address bits of any CPU write to one of two 4 KiB decode ranges. A write to one I/O address sets a nametable mirroring flag from a data bit. All of this state is registered and changes on the clock edge that ends the write cycle.

Top module: `cart_window_mapper`

## Requirements
- R1: After a synchronous active-low reset, both page registers hold 31 and mirroring is vertical (`mirror_horiz` = 0). Page A is therefore 31, and page B, which is (31+8) mod 32, is 7.
- R2: A write cycle with address 0x8000–0x8FFF loads page register A with address bits [2:0], and the data bus is ignored. The new value is used from the next clock edge onward.
- R3: A write cycle with address 0x9000–0x9FFF loads page register B with address bits [3:0], and the data bus is ignored. The effective page is (B+8) mod 32, used from the next clock edge onward.
- R4: A write to 0x4025 sets `mirror_horiz` to data bit 3 (1 = horizontal, 0 = vertical) at the next edge. No other access changes it.
- R5: Addresses 0x7000–0x7FFF select ROM with `rom_addr` = {A[4:0], addr[11:0]}.
- R6: Addresses 0x6C00–0x6FFF select ROM at offsets 0x000–0x3FF of page B, and addresses 0xC000–0xCBFF select offsets 0x400–0xFFF of the same page. In both cases `rom_addr` = {pageB[4:0], offset[11:0]}.
- R7: RAM is selected in three windows. 0x6000–0x6BFF maps to RAM 0x0000–0x0BFF, 0xB800–0xBFFF maps to RAM 0x0C00–0x13FF, and 0xCC00–0xD7FF maps to RAM 0x1400–0x1FFF.
- R8: All other addresses in 0x8000–0xFFFF select ROM at 0x18000 + addr[14:0], which is {2'b11, addr[14:0]}.
- R9: `ram_we` is high only for a write cycle inside a RAM window. A write to any ROM window asserts no write enable. Writes outside 0x8000–0x9FFF leave both page registers unchanged.
- R10: `rom_cs` and `ram_cs` are never high together, and both are low for every address below 0x6000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one CPU access per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | High for a write cycle, low for a read |
| rom_cs | output | 1 | ROM chip select |
| rom_addr | output | 17 | ROM byte address |
| ram_cs | output | 1 | Work RAM chip select |
| ram_we | output | 1 | Work RAM write enable |
| ram_addr | output | 13 | Work RAM byte address |
| mirror_horiz | output | 1 | 1 = horizontal nametable mirroring, 0 = vertical |

## Verification
The overlap that matters is a page register update falling in the same cycle as a decode that uses that page. A write to 0x8000–0x9FFF is followed directly by a read of a page window, and the bench expects the old page during the write cycle and the new page on the next one. Random address streams weighted toward the window edges mix register writes, RAM writes and reads back to back. Each cycle's combinational outputs are compared with a bench model whose registers advance only at the clock edge.

// File: rtl/cwm_pkg.sv
// Package: shared widths and the window classification used by the mapper.
// Assumes a 16-bit CPU address, 4 KiB ROM pages and 8 KiB of work RAM.
package cwm_pkg;
    localparam int CPU_AW   = 16;
    localparam int DATA_W   = 8;
    localparam int PAGE_W   = 5;
    localparam int OFF_W    = 12;
    localparam int ROM_AW   = PAGE_W + OFF_W;
    localparam int RAM_AW   = 13;
    localparam int FIX_W    = ROM_AW - 15;
    localparam logic [PAGE_W-1:0] PAGE_RST = '1;
    localparam logic [PAGE_W-1:0] B_BIAS   = PAGE_W'(8);

    typedef enum logic [2:0] {
        WIN_NONE,
        WIN_RAM_LO,
        WIN_PGB_LO,
        WIN_PGA,
        WIN_FIXED,
        WIN_RAM_MID,
        WIN_PGB_HI,
        WIN_RAM_HI
    } win_e;
endpackage

// File: rtl/cwm_page_regs.sv
// Page and mirroring registers.
// Captures page numbers from address bits of CPU writes and the mirroring
// flag from a data bit. Assumes one access per clock and that cpu_we marks a
// write cycle whose effect lands on the closing edge.
module cwm_page_regs
    import cwm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CPU_AW-1:0]    cpu_addr,
    input  logic [DATA_W-1:0]    cpu_wdata,
    input  logic                 cpu_we,
    output logic [PAGE_W-1:0]    page_a,
    output logic [PAGE_W-1:0]    page_b,
    output logic                 mirror_horiz
);
    localparam logic [3:0]        NIB_A   = 4'h8;
    localparam logic [3:0]        NIB_B   = 4'h9;
    localparam logic [CPU_AW-1:0] MIR_ADR = 16'h4025;

    logic [PAGE_W-1:0] reg_a;
    logic [PAGE_W-1:0] reg_b;
    logic              hit_a;
    logic              hit_b;
    logic              hit_m;

    // Purpose: flag writes that target each register.
    always_comb begin
        hit_a = cpu_we && (cpu_addr[15:12] == NIB_A);
        hit_b = cpu_we && (cpu_addr[15:12] == NIB_B);
        hit_m = cpu_we && (cpu_addr == MIR_ADR);
    end

    // Purpose: hold the page registers and the mirroring flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_a        <= PAGE_RST;
            reg_b        <= PAGE_RST;
            mirror_horiz <= 1'b0;
        end else begin
            if (hit_a) reg_a <= {{(PAGE_W-3){1'b0}}, cpu_addr[2:0]};
            if (hit_b) reg_b <= {{(PAGE_W-4){1'b0}}, cpu_addr[3:0]};
            if (hit_m) mirror_horiz <= cpu_wdata[3];
        end
    end

    // Purpose: present effective pages; B is biased by 8 with modulo wrap.
    always_comb begin
        page_a = reg_a;
        page_b = reg_b + B_BIAS;
    end

    AST_PAGE_A_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr[15:12] == 4'h8) |=> (page_a[2:0] == $past(cpu_addr[2:0]) && page_a[PAGE_W-1:3] == '0)) // R2
        else $error("page A load");
    AST_PAGE_B_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr[15:12] == 4'h9) |=> (page_b == PAGE_W'($past(cpu_addr[3:0]) + 8))) // R3
        else $error("page B load");
    AST_PAGES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_we && (cpu_addr[15:12] == 4'h8 || cpu_addr[15:12] == 4'h9)) |=> ($stable(page_a) && $stable(page_b))) // R9
        else $error("pages moved");
    AST_MIRROR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_we && cpu_addr == 16'h4025) |=> $stable(mirror_horiz)) // R4
        else $error("mirror moved");
endmodule

// File: rtl/cwm_decode.sv
// Window decoder.
// Classifies the CPU address into one window and forms the ROM or RAM
// address. Purely combinational; assumes pages are already effective values.
module cwm_decode
    import cwm_pkg::*;
(
    input  logic [CPU_AW-1:0]    cpu_addr,
    input  logic                 cpu_we,
    input  logic [PAGE_W-1:0]    page_a,
    input  logic [PAGE_W-1:0]    page_b,
    output logic                 rom_cs,
    output logic [ROM_AW-1:0]    rom_addr,
    output logic                 ram_cs,
    output logic                 ram_we,
    output logic [RAM_AW-1:0]    ram_addr
);
    win_e              win;
    logic [CPU_AW-1:0] ram_diff;
    logic [OFF_W-1:0]  off;

    // Purpose: pick the window; ordered by ascending address boundary.
    always_comb begin
        if      (cpu_addr < 16'h6000) win = WIN_NONE;
        else if (cpu_addr < 16'h6C00) win = WIN_RAM_LO;
        else if (cpu_addr < 16'h7000) win = WIN_PGB_LO;
        else if (cpu_addr < 16'h8000) win = WIN_PGA;
        else if (cpu_addr < 16'hB800) win = WIN_FIXED;
        else if (cpu_addr < 16'hC000) win = WIN_RAM_MID;
        else if (cpu_addr < 16'hCC00) win = WIN_PGB_HI;
        else if (cpu_addr < 16'hD800) win = WIN_RAM_HI;
        else                          win = WIN_FIXED;
    end

    // Purpose: rebase RAM windows so they tile RAM contiguously.
    always_comb begin
        case (win)
            WIN_RAM_MID: ram_diff = cpu_addr - 16'hAC00;
            WIN_RAM_HI:  ram_diff = cpu_addr - 16'hB800;
            default:     ram_diff = cpu_addr - 16'h6000;
        endcase
        ram_addr = ram_diff[RAM_AW-1:0];
        ram_cs   = (win == WIN_RAM_LO) || (win == WIN_RAM_MID) || (win == WIN_RAM_HI);
        ram_we   = ram_cs && cpu_we;
    end

    // Purpose: form the ROM address for banked and fixed windows.
    always_comb begin
        off      = cpu_addr[OFF_W-1:0];
        rom_cs   = 1'b1;
        rom_addr = '0;
        case (win)
            WIN_PGA:    rom_addr = {page_a, off};
            WIN_PGB_LO: rom_addr = {page_b, {(OFF_W-10){1'b0}}, off[9:0]};
            WIN_PGB_HI: rom_addr = {page_b, off + OFF_W'(12'h400)};
            WIN_FIXED:  rom_addr = {{FIX_W{1'b1}}, cpu_addr[14:0]};
            default:    rom_cs   = 1'b0;
        endcase
    end
endmodule

// File: rtl/cart_window_mapper.sv
// Top of the cartridge window mapper.
// Joins the page/mirroring registers with the window decoder. Assumes one
// CPU access per clock; the decode responds within the same cycle.
module cart_window_mapper
    import cwm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [15:0]          cpu_addr,
    input  logic [7:0]           cpu_wdata,
    input  logic                 cpu_we,
    output logic                 rom_cs,
    output logic [16:0]          rom_addr,
    output logic                 ram_cs,
    output logic                 ram_we,
    output logic [12:0]          ram_addr,
    output logic                 mirror_horiz
);
    logic [PAGE_W-1:0] page_a;
    logic [PAGE_W-1:0] page_b;

    cwm_page_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_addr     (cpu_addr),
        .cpu_wdata    (cpu_wdata),
        .cpu_we       (cpu_we),
        .page_a       (page_a),
        .page_b       (page_b),
        .mirror_horiz (mirror_horiz)
    );

    cwm_decode u_dec (
        .cpu_addr (cpu_addr),
        .cpu_we   (cpu_we),
        .page_a   (page_a),
        .page_b   (page_b),
        .rom_cs   (rom_cs),
        .rom_addr (rom_addr),
        .ram_cs   (ram_cs),
        .ram_we   (ram_we),
        .ram_addr (ram_addr)
    );

    AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_cs && ram_cs)) // R10
        else $error("both selects");
    AST_LOW_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr < 16'h6000) |-> (!rom_cs && !ram_cs)) // R10
        else $error("low map selected");
    AST_WE_RAM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_cs && cpu_we)) // R9
        else $error("stray write enable");
    AST_RAM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_cs && cpu_addr >= 16'hCC00) |-> (ram_addr >= 13'h1400)) // R7
        else $error("high RAM window rebase");
endmodule

// File: tb/test_cart_window_mapper.sv
module test_cart_window_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_we = 1'b0;
    logic        rom_cs, ram_cs, ram_we, mirror_horiz;
    logic [16:0] rom_addr;
    logic [12:0] ram_addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [4:0] m_a = 5'd31;
    logic [4:0] m_b = 5'd31;
    logic       m_mir = 1'b0;

    always #2.5 clk = ~clk;

    cart_window_mapper i_cart_window_mapper (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_we(cpu_we), .rom_cs(rom_cs), .rom_addr(rom_addr), .ram_cs(ram_cs),
        .ram_we(ram_we), .ram_addr(ram_addr), .mirror_horiz(mirror_horiz)
    );

    function automatic bit is_ram(input logic [15:0] a);
        return (a >= 16'h6000 && a < 16'h6C00) || (a >= 16'hB800 && a < 16'hC000) ||
               (a >= 16'hCC00 && a < 16'hD800);
    endfunction

    function automatic bit is_rom(input logic [15:0] a);
        return (a >= 16'h6000) && !is_ram(a);
    endfunction

    function automatic logic [12:0] exp_ram(input logic [15:0] a);
        if (a < 16'h6C00) return 13'(a - 16'h6000);          // R7 low window
        if (a < 16'hC000) return 13'(32'h0C00 + a - 16'hB800); // R7 middle window
        return 13'(32'h1400 + a - 16'hCC00);                   // R7 high window
    endfunction

    function automatic logic [16:0] exp_rom(input logic [15:0] a);
        logic [4:0] pb;
        pb = m_b + 5'd8;
        if (a >= 16'h6C00 && a < 16'h7000) return {pb, 12'(a - 16'h6C00)};
        if (a >= 16'h7000 && a < 16'h8000) return {m_a, 12'(a - 16'h7000)};
        if (a >= 16'hC000 && a < 16'hCC00) return {pb, 12'(32'h400 + a - 16'hC000)};
        return 17'h18000 + 17'(a[14:0]);
    endfunction

    function automatic string tag_of(input logic [15:0] a);
        if (a < 16'h6000) return "R10";
        if (is_ram(a)) return "R7";
        if (a >= 16'h7000 && a < 16'h8000) return "R5";
        if ((a >= 16'h6C00 && a < 16'h7000) || (a >= 16'hC000 && a < 16'hCC00)) return "R6";
        return "R8";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, cpu_addr, act, exp);
        end
    endtask

    // One access: drive at negedge, check the decode mid-cycle, advance model at posedge.
    task automatic access(input logic [15:0] a, input logic [7:0] d, input logic we, input string tag);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_we = we;
        #1;
        check("R10", {30'd0, rom_cs, ram_cs}, {30'd0, is_rom(a), is_ram(a)});
        check("R9", {31'd0, ram_we}, {31'd0, we && is_ram(a)});
        if (is_rom(a)) check(tag == "" ? tag_of(a) : tag, 32'(rom_addr), 32'(exp_rom(a)));
        if (is_ram(a)) check(tag == "" ? tag_of(a) : tag, 32'(ram_addr), 32'(exp_ram(a)));
        check("R4", {31'd0, mirror_horiz}, {31'd0, m_mir});
        @(posedge clk);
        if (we && a[15:12] == 4'h8) m_a = {2'b00, a[2:0]};   // R2
        if (we && a[15:12] == 4'h9) m_b = {1'b0, a[3:0]};    // R3
        if (we && a == 16'h4025) m_mir = d[3];               // R4
    endtask

    function automatic logic [15:0] pick_addr();
        logic [15:0] edges [16] = '{16'h5FFF, 16'h6000, 16'h6BFF, 16'h6C00, 16'h6FFF, 16'h7000,
            16'h7FFF, 16'h8000, 16'hB7FF, 16'hB800, 16'hBFFF, 16'hC000, 16'hCBFF, 16'hCC00,
            16'hD7FF, 16'hD800};
        int sel;
        sel = $urandom_range(0, 9);
        if (sel < 2) return edges[$urandom_range(0, 15)];
        if (sel < 4) return 16'h8000 | 16'($urandom_range(0, 16'h1FFF));
        if (sel == 4) return 16'h4025;
        if (sel < 8) return 16'h6000 | 16'($urandom_range(0, 16'h1FFF));
        return 16'($urandom_range(0, 16'hFFFF));
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stimulus
        void'($urandom(32'h1234ABCD));
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset pages 31 and (31+8) mod 32 = 7, mirroring vertical
        @(negedge clk);
        cpu_addr = 16'h7000; #1;
        check("R1", 32'(rom_addr), 32'h1F000);
        cpu_addr = 16'h6C00; #1;
        check("R1", 32'(rom_addr), 32'h07000);
        check("R1", {31'd0, mirror_horiz}, 32'd0);
        // R2: page A from address bits, data ignored; old page holds in the write cycle
        access(16'h8FF5, 8'hFF, 1'b1, "R2");
        access(16'h7123, 8'h00, 1'b0, "R2");
        check("R2", 32'(rom_addr), 32'h05123);
        // R3: page B from address bits, biased by 8
        access(16'h9ABF, 8'h00, 1'b1, "R3");
        access(16'hC000, 8'h00, 1'b0, "R3");
        check("R3", 32'(rom_addr), 32'h17400);
        access(16'h6FFF, 8'h00, 1'b0, "R6");
        check("R6", 32'(rom_addr), 32'h173FF);
        // R4: mirroring from data bit 3
        access(16'h4025, 8'h08, 1'b1, "R4");
        access(16'h4024, 8'h00, 1'b1, "R4");
        check("R4", {31'd0, mirror_horiz}, 32'd1);
        access(16'h4025, 8'hF7, 1'b1, "R4");
        access(16'h0000, 8'h00, 1'b0, "R10");
        check("R4", {31'd0, mirror_horiz}, 32'd0);
        // R9: writes to RAM and fixed ROM windows leave pages unchanged
        access(16'hBC01, 8'h55, 1'b1, "R9");
        access(16'hA003, 8'h55, 1'b1, "R9");
        access(16'h7FFF, 8'h00, 1'b0, "R9");
        check("R9", 32'(rom_addr), 32'h05FFF);
        // R7/R8/R10 window edges, read and write
        for (int i = 0; i < 2; i++) begin
            access(16'h5FFF, 8'h11, 1'(i), "");
            access(16'h6BFF, 8'h11, 1'(i), "");
            access(16'hB7FF, 8'h11, 1'(i), "");
            access(16'hB800, 8'h11, 1'(i), "");
            access(16'hCBFF, 8'h11, 1'(i), "");
            access(16'hCC00, 8'h11, 1'(i), "");
            access(16'hD7FF, 8'h11, 1'(i), "");
            access(16'hD800, 8'h11, 1'(i), "");
            access(16'hFFFF, 8'h11, 1'(i), "");
        end
        // Random mix
        for (int n = 0; n < 4000; n++) begin
            access(pick_addr(), 8'($urandom), 1'($urandom_range(0, 1)), "");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule